// File: doc/BRIEF.md
# Pause Frame Inserter

This block adds Ethernet flow-control (pause) frames to a byte-wide transmit stream. Software programs the frame properties in a small register set: the addressing mode, a 16-bit pause time and a 48-bit unicast destination. It then writes to a trigger register. Each trigger causes the block to build one 60-byte pause frame and place it into the outgoing stream. The frame check sequence is added further downstream.

The block sits between the normal transmit source and the next stage of the transmit path. Both sides use a valid/ready byte stream with start-of-packet and end-of-packet markers. When no pause frame is due, user bytes pass straight through. When a pause frame is due, it is sent at the next packet boundary, so a user packet is never split.

The register values are captured at the moment of the trigger. If a second trigger arrives while a frame is still waiting or being sent, it merges with that request.

Top module: `pause_inserter`

## Requirements
- R1: A write to register address 4 requests exactly one pause frame, whatever the write data is. With the output free, the first frame byte is offered on the cycle after the write. The other register addresses are: 0 control (bit 0 is the mode), 1 pause time (bits 15:0), 2 destination low word (bits 31:0) and 3 destination high word (bits 15:0).
- R2: When control bit 0 is 1, the destination is 01-80-C2-00-00-01. When it is 0, the destination is {high[15:0], low[31:0]}, and the most significant byte is sent first. The bit resets to 0.
- R3: A frame is exactly 60 bytes, in this order: destination (6 bytes), the SRC_MAC parameter with its most significant byte first (6 bytes), 0x88 0x08, 0x00 0x01, the pause time with its most significant byte first, then 42 zero bytes. o_sop is set on byte 0 only, and o_eop on byte 59 only.
- R4: A pause time of zero is sent as two zero bytes. It is not suppressed.
- R5: While o_valid is high and o_ready is low, the offered pause byte and its markers stay unchanged.
- R6: A trigger that arrives during a user packet is held until that packet's end byte has been accepted. The pause frame then goes out before the next user packet. Output packets never interleave.
- R7: The pause time, mode and destination are captured at the trigger. Register writes made later do not change a frame that is waiting or being sent, but they do apply to the next trigger.
- R8: A trigger that arrives while a frame is waiting or being sent does not add a frame.
- R9: After reset, no frame is pending and o_valid follows u_valid.
- R10: When no pause frame is selected, u_ready equals o_ready and the user bytes and markers pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 32 | Register write data |
| u_valid | input | 1 | User stream byte valid |
| u_ready | output | 1 | User stream ready |
| u_data | input | 8 | User stream byte |
| u_sop | input | 1 | User start of packet |
| u_eop | input | 1 | User end of packet |
| o_valid | output | 1 | Output byte valid |
| o_ready | input | 1 | Output ready from downstream |
| o_data | output | 8 | Output byte |
| o_sop | output | 1 | Output start of packet |
| o_eop | output | 1 | Output end of packet |

## Verification
The assertions check on every cycle that:
- a stalled pause byte holds still;
- every emitted pause frame ends on exactly its sixtieth accepted byte;
- no start marker appears inside an open output packet;
- a trigger that lands on a busy request neither reloads the captured values nor drops the request.

Only the bench scenarios can show the byte contents of a frame under each mode and pause time. They also show where the frame lands relative to user packets, and that writes made after a trigger take effect only on the next frame.

// File: rtl/pause_ins_pkg.sv
package pause_ins_pkg;
   localparam int          FRAME_LEN = 60;
   localparam logic [47:0] FC_GROUP  = 48'h0180_C200_0001;
   localparam logic [15:0] ETYPE_MAC_CTRL = 16'h8808;
   localparam logic [15:0] OPC_PAUSE = 16'h0001;

   localparam int A_CTRL = 0;
   localparam int A_TIME = 1;
   localparam int A_DLO  = 2;
   localparam int A_DHI  = 3;
   localparam int A_TRIG = 4;

   typedef struct packed {
      logic        mcast;
      logic [15:0] ptime;
      logic [47:0] dst;
   } pause_cfg_t;

   // byte at position pos of the pause frame (FCS excluded)
   function automatic logic [7:0] pause_byte(input int unsigned pos,
                                             input logic [47:0] da,
                                             input logic [47:0] sa,
                                             input logic [15:0] t);
      logic [47:0] sh;
      logic [7:0]  b;
      b  = 8'h00;
      sh = '0;
      if (pos < 6) begin
         sh = da >> (8 * (5 - pos));
         b  = sh[7:0];
      end else if (pos < 12) begin
         sh = sa >> (8 * (11 - pos));
         b  = sh[7:0];
      end else begin
         case (pos)
            12:      b = ETYPE_MAC_CTRL[15:8];
            13:      b = ETYPE_MAC_CTRL[7:0];
            14:      b = OPC_PAUSE[15:8];
            15:      b = OPC_PAUSE[7:0];
            16:      b = t[15:8];
            17:      b = t[7:0];
            default: b = 8'h00;
         endcase
      end
      return b;
   endfunction
endpackage

// File: rtl/pause_regs.sv
module pause_regs
   import pause_ins_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output pause_cfg_t        cfg,
   output logic              trig
);
   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_TIME = ADDR_W'(A_TIME);
   localparam logic [ADDR_W-1:0] AD_DLO  = ADDR_W'(A_DLO);
   localparam logic [ADDR_W-1:0] AD_DHI  = ADDR_W'(A_DHI);
   localparam logic [ADDR_W-1:0] AD_TRIG = ADDR_W'(A_TRIG);

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("pause_regs: ADDR_W must reach address %0d", A_TRIG);
      end
   endgenerate

   logic        mcast_q;
   logic [15:0] time_q;
   logic [31:0] dlo_q;
   logic [15:0] dhi_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcast_q <= 1'b0;
         time_q  <= '0;
         dlo_q   <= '0;
         dhi_q   <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            AD_CTRL: mcast_q <= reg_wdata[0];
            AD_TIME: time_q  <= reg_wdata[15:0];
            AD_DLO:  dlo_q   <= reg_wdata;
            AD_DHI:  dhi_q   <= reg_wdata[15:0];
            default: ;
         endcase
      end
   end

   assign trig      = reg_wr && (reg_addr == AD_TRIG);
   assign cfg.mcast = mcast_q;
   assign cfg.ptime = time_q;
   assign cfg.dst   = {dhi_q, dlo_q};
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
   import pause_ins_pkg::*;
#(
   parameter int          LEN     = FRAME_LEN,
   parameter logic [47:0] SRC_MAC = 48'h02AA_BBCC_DDEE
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trig,
   input  pause_cfg_t  cfg,
   input  logic        take,
   output logic        g_valid,
   output logic [7:0]  g_data,
   output logic        g_sop,
   output logic        g_eop,
   output logic [15:0] snap_time
);
   localparam int IDX_W = $clog2(LEN);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

   generate
      if (LEN < FRAME_LEN) begin : g_bad_len
         $error("pause_frame_gen: LEN below minimum frame size");
      end
   endgenerate

   logic             pend;
   logic [IDX_W-1:0] idx;
   logic [47:0]      snap_da;
   logic [15:0]      snap_t;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         idx     <= '0;
         snap_da <= '0;
         snap_t  <= '0;
      end else if (!pend && trig) begin
         pend    <= 1'b1;
         idx     <= '0;
         snap_da <= cfg.mcast ? FC_GROUP : cfg.dst;
         snap_t  <= cfg.ptime;
      end else if (pend && take) begin
         if (idx == LAST) begin
            pend <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assign g_valid   = pend;
   assign g_data    = pause_byte(32'(idx), snap_da, SRC_MAC, snap_t);
   assign g_sop     = pend && (idx == '0);
   assign g_eop     = pend && (idx == LAST);
   assign snap_time = snap_t;
endmodule

// File: rtl/pause_tx_arb.sv
module pause_tx_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       g_valid,
   input  logic [7:0] g_data,
   input  logic       g_sop,
   input  logic       g_eop,
   output logic       g_take,
   input  logic       u_valid,
   output logic       u_ready,
   input  logic [7:0] u_data,
   input  logic       u_sop,
   input  logic       u_eop,
   output logic       o_valid,
   input  logic       o_ready,
   output logic [7:0] o_data,
   output logic       o_sop,
   output logic       o_eop,
   output logic       pause_sel
);
   logic in_user;

   // a pending frame takes the output only between user packets
   assign pause_sel = g_valid && !in_user;

   always_ff @(posedge clk) begin
      if (!rst_n)
         in_user <= 1'b0;
      else if (!pause_sel && u_valid && o_ready)
         in_user <= !u_eop;
   end

   assign o_valid = pause_sel ? 1'b1   : u_valid;
   assign o_data  = pause_sel ? g_data : u_data;
   assign o_sop   = pause_sel ? g_sop  : u_sop;
   assign o_eop   = pause_sel ? g_eop  : u_eop;
   assign u_ready = !pause_sel && o_ready;
   assign g_take  = pause_sel && o_ready;
endmodule

// File: rtl/pause_inserter.sv
module pause_inserter
   import pause_ins_pkg::*;
#(
   parameter int          ADDR_W  = 3,
   parameter int          LEN     = FRAME_LEN,
   parameter logic [47:0] SRC_MAC = 48'h02AA_BBCC_DDEE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              u_valid,
   output logic              u_ready,
   input  logic [7:0]        u_data,
   input  logic              u_sop,
   input  logic              u_eop,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [7:0]        o_data,
   output logic              o_sop,
   output logic              o_eop
);
   pause_cfg_t  cfg;
   logic        trig_pulse;
   logic        g_valid, g_sop, g_eop, g_take, pause_sel;
   logic [7:0]  g_data;
   logic [15:0] snap_time;

   pause_regs #(.ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .cfg(cfg), .trig(trig_pulse)
   );

   pause_frame_gen #(.LEN(LEN), .SRC_MAC(SRC_MAC)) i_gen (
      .clk(clk), .rst_n(rst_n), .trig(trig_pulse), .cfg(cfg), .take(g_take),
      .g_valid(g_valid), .g_data(g_data), .g_sop(g_sop), .g_eop(g_eop),
      .snap_time(snap_time)
   );

   pause_tx_arb i_arb (
      .clk(clk), .rst_n(rst_n),
      .g_valid(g_valid), .g_data(g_data), .g_sop(g_sop), .g_eop(g_eop),
      .g_take(g_take),
      .u_valid(u_valid), .u_ready(u_ready), .u_data(u_data),
      .u_sop(u_sop), .u_eop(u_eop),
      .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
      .o_sop(o_sop), .o_eop(o_eop), .pause_sel(pause_sel)
   );
endmodule

// File: rtl/pause_inserter_chk.sv
module pause_inserter_chk #(
   parameter int LEN = 60
) (
   input logic        clk,
   input logic        rst_n,
   input logic        o_valid,
   input logic        o_ready,
   input logic [7:0]  o_data,
   input logic        o_sop,
   input logic        o_eop,
   input logic        sel,
   input logic        busy,
   input logic        trig,
   input logic [15:0] snap_time
);
   logic       pkt_open;
   logic [7:0] nbytes;
   logic       acc, p_acc;

   assign acc   = o_valid && o_ready;
   assign p_acc = sel && acc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_open <= 1'b0;
         nbytes   <= '0;
      end else begin
         if (acc) pkt_open <= !o_eop;
         if (p_acc) nbytes <= o_eop ? 8'd0 : nbytes + 8'd1;
      end
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !o_ready) |=> (sel && $stable(o_data) && $stable(o_sop) && $stable(o_eop))); // R5
   AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (p_acc && o_eop) |-> (nbytes == 8'(LEN - 1))); // R3
   AST_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && o_sop) |-> !pkt_open); // R6
   AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig) |=> $stable(snap_time)); // R7
   AST_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && trig && !(p_acc && o_eop)) |=> busy); // R8
endmodule

bind pause_inserter pause_inserter_chk #(.LEN(LEN)) i_chk (
   .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
   .o_data(o_data), .o_sop(o_sop), .o_eop(o_eop), .sel(pause_sel),
   .busy(g_valid), .trig(trig_pulse), .snap_time(snap_time)
);

// File: tb/test_pause_inserter.sv
`timescale 1ns/1ps
module test_pause_inserter;
   localparam logic [47:0] TB_SA = 48'h0A1B_2C3D_4E5F;
   localparam logic [47:0] GRP   = 48'h0180_C200_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic u_valid = 1'b0, u_sop = 1'b0, u_eop = 1'b0;
   logic [7:0] u_data = '0;
   logic u_ready, o_valid, o_sop, o_eop;
   logic o_ready = 1'b1;
   logic [7:0] o_data;

   always #2 clk = ~clk;

   pause_inserter #(.SRC_MAC(TB_SA)) i_pause_inserter (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .u_valid(u_valid), .u_ready(u_ready),
      .u_data(u_data), .u_sop(u_sop), .u_eop(u_eop), .o_valid(o_valid),
      .o_ready(o_ready), .o_data(o_data), .o_sop(o_sop), .o_eop(o_eop)
   );

   int n_chk = 0, n_bad = 0;
   logic [7:0] cap_d [0:255];
   logic       cap_s [0:255];
   logic       cap_e [0:255];
   int cap_n = 0;

   always @(negedge clk)
      if (rst_n && o_valid && o_ready && cap_n < 256) begin
         cap_d[cap_n] = o_data;
         cap_s[cap_n] = o_sop;
         cap_e[cap_n] = o_eop;
         cap_n = cap_n + 1;
      end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic reg_write(input int a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      step(1);
      reg_wr = 1'b0;
   endtask

   function automatic logic [7:0] exp_byte(input int i, input logic [47:0] da,
                                           input logic [15:0] t);
      if (i < 6)  return da[8*(5-i) +: 8];
      if (i < 12) return TB_SA[8*(11-i) +: 8];
      case (i)
         12: return 8'h88;
         13: return 8'h08;
         14: return 8'h00;
         15: return 8'h01;
         16: return t[15:8];
         17: return t[7:0];
         default: return 8'h00;
      endcase
   endfunction

   task automatic check_frame(input int base, input logic [47:0] da,
                              input logic [15:0] t, input string req);
      int bad_at = -1;
      logic [9:0] a = '0, e = '0;
      for (int i = 0; i < 60; i++) begin
         logic [9:0] av, ev;
         av = {cap_s[base+i], cap_e[base+i], cap_d[base+i]};
         ev = {i == 0, i == 59, exp_byte(i, da, t)};
         if (bad_at < 0 && av !== ev) begin bad_at = i; a = av; e = ev; end
      end
      chk(bad_at < 0, req, $sformatf("frame byte %0d {sop,eop,data}", bad_at), a, e);
   endtask

   task automatic send_user(input int len, input logic [7:0] base);
      for (int i = 0; i < len; i++) begin
         u_valid = 1'b1; u_data = base + 8'(i);
         u_sop = (i == 0); u_eop = (i == len - 1);
         @(negedge clk);
         while (!u_ready) @(negedge clk);
         step(1);
      end
      u_valid = 1'b0; u_sop = 1'b0; u_eop = 1'b0;
   endtask

   task automatic t_reset;
      o_ready = 1'b0;
      step(2);
      chk(o_valid === 1'b0, "R9", "o_valid after reset", o_valid, 0);
      chk(u_ready === 1'b0, "R10", "u_ready with o_ready low", u_ready, 0);
      u_valid = 1'b1; u_data = 8'h5A; u_sop = 1'b1; u_eop = 1'b1; o_ready = 1'b1;
      #1;
      chk(o_valid && o_data == 8'h5A && o_sop && o_eop && u_ready, "R10",
          "passthrough {v,d,s,e,rdy}", {o_valid, o_data, o_sop, o_eop, u_ready},
          {1'b1, 8'h5A, 3'b111});
      u_valid = 1'b0; u_sop = 1'b0; u_eop = 1'b0;
      step(1);
      cap_n = 0;
   endtask

   task automatic t_unicast_stall;
      o_ready = 1'b0;
      reg_write(2, 32'h3344_5566);
      reg_write(3, 32'hFFFF_1122);
      reg_write(1, 32'hABCD_1234);
      reg_write(4, 32'h0);
      #1;
      chk(o_valid && o_sop && o_data == 8'h11, "R1", "first byte after trigger",
          {o_valid, o_sop, o_data}, {2'b11, 8'h11});
      step(5);
      chk(o_valid && o_sop && o_data == 8'h11 && !o_eop, "R5", "held byte under stall",
          {o_valid, o_sop, o_data}, {2'b11, 8'h11});
      o_ready = 1'b1;
      step(80);
      chk(cap_n == 60, "R1", "unicast byte count", cap_n, 60);
      check_frame(0, 48'h1122_3344_5566, 16'h1234, "R2 R3 unicast");
      cap_n = 0;
   endtask

   task automatic t_multicast_zero;
      reg_write(0, 32'h1);
      reg_write(1, 32'h0);
      reg_write(4, 32'hDEAD_BEEF);
      step(80);
      chk(cap_n == 60, "R1", "multicast byte count", cap_n, 60);
      check_frame(0, GRP, 16'h0000, "R2 R4 multicast zero time");
      cap_n = 0;
      reg_write(0, 32'h0);
   endtask

   task automatic t_mid_packet;
      reg_write(1, 32'h0000_0777);
      fork
         begin send_user(10, 8'h40); send_user(5, 8'hC0); end
         begin step(3); reg_write(4, 32'h1); end
      join
      step(80);
      chk(cap_n == 75, "R6", "total bytes", cap_n, 75);
      for (int i = 0; i < 10; i++)
         chk(cap_d[i] == 8'h40 + 8'(i) && cap_s[i] == (i == 0) && cap_e[i] == (i == 9),
             "R10", $sformatf("user A byte %0d", i), cap_d[i], 8'h40 + 8'(i));
      check_frame(10, 48'h1122_3344_5566, 16'h0777, "R6 frame after packet end");
      chk(cap_s[70] && cap_d[70] == 8'hC0, "R6", "next user packet follows frame",
          {cap_s[70], cap_d[70]}, {1'b1, 8'hC0});
      chk(cap_e[74] && cap_d[74] == 8'hC4, "R6", "user B last byte",
          {cap_e[74], cap_d[74]}, {1'b1, 8'hC4});
      cap_n = 0;
   endtask

   task automatic t_merge;
      reg_write(1, 32'h0000_0042);
      reg_write(4, 32'h0);
      reg_write(4, 32'h0);
      step(6);
      reg_write(4, 32'h5);
      step(100);
      chk(cap_n == 60, "R8", "merged triggers give one frame", cap_n, 60);
      check_frame(0, 48'h1122_3344_5566, 16'h0042, "R8 merged frame");
      cap_n = 0;
   endtask

   task automatic t_snapshot;
      reg_write(1, 32'h0000_1111);
      reg_write(4, 32'h0);
      reg_write(1, 32'h0000_BEEF);
      reg_write(0, 32'h1);
      reg_write(2, 32'h0);
      step(80);
      chk(cap_n == 60, "R7", "byte count", cap_n, 60);
      check_frame(0, 48'h1122_3344_5566, 16'h1111, "R7 captured values");
      cap_n = 0;
      reg_write(4, 32'h0);
      step(80);
      check_frame(0, GRP, 16'hBEEF, "R7 new values on next trigger");
      cap_n = 0;
      reg_write(0, 32'h0);
   endtask

   task automatic t_backpressure;
      reg_write(1, 32'h0000_9A0B);
      reg_write(4, 32'h0);
      for (int i = 0; i < 200; i++) begin
         o_ready = (i % 3) != 1;
         step(1);
      end
      o_ready = 1'b1;
      step(2);
      chk(cap_n == 60, "R5", "byte count under backpressure", cap_n, 60);
      check_frame(0, 48'h1122_0000_0000, 16'h9A0B, "R5 R3 frame under backpressure");
      cap_n = 0;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_unicast_stall();
      t_multicast_zero();
      t_mid_packet();
      t_merge();
      t_snapshot();
      t_backpressure();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #800000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule